// File: doc/BRIEF.md
# Per-CPU Local Interrupt Interface

This block is the window that one processor core sees into a multiprocessor interrupt controller. It accepts 32 private interrupt lines that belong to this core only, plus the shared requests that a central distributor has already routed to this core. It then presents one interrupt line to the core. Software works through a small register port. It sets the sensing mode of each private line, turns single IDs on or off by writing their number, and claims the next ID to service by reading a ready register. It finishes an ID by writing its number to a completion register.

IDs 0 to 31 are private and IDs 32 to 63 are shared. A claimed ID is marked active and is not offered again until it is completed. Completing a shared ID sends a one-cycle clear pulse back to the distributor, so that it can retire its request.

Top module: `lic_local_cpu`

## Requirements
- R1: After reset the control enable is 0, every ID is disabled and inactive, every private mode is 0, `core_irq_o` is 0, `shared_clr_o` is 0, and a read of the ready register (byte offset 0x10) returns 0x3FF.
- R2: Bit 0 of the control register (offset 0x00) is the local enable and reads back. While it is 0, `core_irq_o` is 0 and a ready read returns 0x3FF without claiming anything.
- R3: The private mode registers sit at offset 0x40 (IDs 0 to 15) and 0x44 (IDs 16 to 31), with ID i using bits [2(i mod 16)+1 : 2(i mod 16)]. They read back as written. Codes: 0 is level high, 1 is level low, 2 is rising edge, 3 is falling edge.
- R4: In a level mode, a private ID is pending while its line is at the active level.
- R5: In an edge mode, a private ID becomes pending on the selected edge and stays pending until it is claimed, even after the line returns.
- R6: Writing an ID in bits [9:0] to offset 0x14 enables that ID, and writing it to offset 0x18 disables it. Values of 64 or more have no effect.
- R7: A ready read returns the lowest-numbered ID that is pending, enabled and not active, and marks that ID active. When there is no such ID, the read returns 0x3FF.
- R8: `core_irq_o` is 1 within two cycles when the local enable is set and some ID is pending, enabled and not active. It returns to 0 once no such ID remains.
- R9: Writing an ID to offset 0x1C clears its active mark. For a shared ID s (32 to 63), bit s-32 of `shared_clr_o` is high for exactly the one cycle after the write.
- R10: When a new edge on a private edge-mode ID arrives in the same cycle in which that ID is claimed, the ID remains pending after the claim.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, held until the next read |
| priv_irq_i | input | 32 | Private interrupt lines, IDs 0 to 31 |
| shared_req_i | input | 32 | Routed shared requests, level, IDs 32 to 63 |
| core_irq_o | output | 1 | Interrupt request to the core |
| shared_clr_o | output | 32 | One-cycle completion pulses for shared IDs |

## Verification
A claim and a fresh edge on the same private edge-mode ID can land in the same cycle. The claim then wants to clear the latched pending bit while the edge wants to set it. The bench provokes this by raising the line on the same falling clock edge on which it starts the ready read. It then completes the ID and reads again: a second return of the same ID shows that the edge was kept, and 0x3FF would show that it was lost. A control run without the second edge must return 0x3FF at that point.

// File: rtl/lic_pkg.sv
package lic_pkg;
  typedef enum logic [1:0] {
    TRIG_LVL_HI = 2'd0,
    TRIG_LVL_LO = 2'd1,
    TRIG_RISE   = 2'd2,
    TRIG_FALL   = 2'd3
  } trig_e;

  localparam logic [7:0] OFS_CTRL     = 8'h00;
  localparam logic [7:0] OFS_READY    = 8'h10;
  localparam logic [7:0] OFS_EN_SET   = 8'h14;
  localparam logic [7:0] OFS_EN_CLR   = 8'h18;
  localparam logic [7:0] OFS_COMPLETE = 8'h1C;
  localparam logic [7:0] OFS_CFG_BASE = 8'h40;
  localparam int         NO_IRQ       = 'h3FF;
endpackage

// File: rtl/lic_trig_unit.sv
module lic_trig_unit
  import lic_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  line_i,
  input  trig_e mode_i,
  input  logic  claim_i,
  output logic  pend_o
);
  logic prev_q;
  logic pend_q;
  logic hit;

  always_comb begin
    case (mode_i)
      TRIG_RISE: hit = line_i & ~prev_q;
      TRIG_FALL: hit = ~line_i & prev_q;
      default:   hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= line_i;
      case (mode_i)
        TRIG_LVL_HI: pend_q <= line_i;
        TRIG_LVL_LO: pend_q <= ~line_i;
        // a new edge wins over a claim in the same cycle
        default:     pend_q <= hit | (pend_q & ~claim_i);
      endcase
    end
  end

  assign pend_o = pend_q;

  // R5: a rising edge in rising mode always leaves the line latched
  assert_edge_latch_R5: assert property (@(posedge clk) disable iff (rst)
    (mode_i == TRIG_RISE && line_i && !prev_q) |=> pend_o);
endmodule

// File: rtl/lic_pick.sv
module lic_pick #(
  parameter int N    = 64,
  parameter int ID_W = 10
) (
  input  logic [N-1:0]    cand_i,
  output logic            valid_o,
  output logic [ID_W-1:0] idx_o
);
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand_i[i]) begin
        valid_o = 1'b1;
        idx_o   = ID_W'(i);
      end
    end
  end
endmodule

// File: rtl/lic_local_cpu.sv
module lic_local_cpu
  import lic_pkg::*;
#(
  parameter int N_PRIV = 32,
  parameter int N_SHR  = 32,
  parameter int ID_W   = 10,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [N_PRIV-1:0] priv_irq_i,
  input  logic [N_SHR-1:0]  shared_req_i,
  output logic              core_irq_o,
  output logic [N_SHR-1:0]  shared_clr_o
);
  localparam int N_TOT     = N_PRIV + N_SHR;
  localparam int CFG_BITS  = 2 * N_PRIV;
  localparam int CFG_WORDS = CFG_BITS / DATA_W;

  logic                ctrl_en_q;
  logic [CFG_BITS-1:0] cfg_q;
  logic [N_TOT-1:0]    en_q, act_q;
  logic                irq_q;
  logic [N_SHR-1:0]    clr_q, clr_d;
  logic [DATA_W-1:0]   rdata_q, rdata_d;

  logic [N_PRIV-1:0]   priv_pend;
  logic [N_TOT-1:0]    pend, cand, claim_vec;
  logic                pick_valid;
  logic [ID_W-1:0]     pick_idx;
  logic [ID_W-1:0]     wid;
  logic                wr_go, rd_go, id_ok;
  logic                en_set_wr, en_clr_wr, eoi_wr, rd_ready, claim_ok;

  assign wr_go     = bus_sel & bus_wr;
  assign rd_go     = bus_sel & ~bus_wr;
  assign wid       = bus_wdata[ID_W-1:0];
  assign id_ok     = (bus_wdata[DATA_W-1:ID_W] == '0) && (int'(wid) < N_TOT);
  assign en_set_wr = wr_go && bus_addr == ADDR_W'(OFS_EN_SET) && id_ok;
  assign en_clr_wr = wr_go && bus_addr == ADDR_W'(OFS_EN_CLR) && id_ok;
  assign eoi_wr    = wr_go && bus_addr == ADDR_W'(OFS_COMPLETE) && id_ok;
  assign rd_ready  = rd_go && bus_addr == ADDR_W'(OFS_READY);
  assign claim_ok  = rd_ready & ctrl_en_q & pick_valid;

  always_comb begin
    for (int i = 0; i < N_TOT; i++)
      claim_vec[i] = claim_ok && (int'(pick_idx) == i);
  end

  // per-line sensing of private IDs
  for (genvar g = 0; g < N_PRIV; g++) begin : g_priv
    lic_trig_unit u_trig (
      .clk    (clk),
      .rst    (rst),
      .line_i (priv_irq_i[g]),
      .mode_i (trig_e'(cfg_q[2*g +: 2])),
      .claim_i(claim_vec[g]),
      .pend_o (priv_pend[g])
    );
  end

  assign pend = {shared_req_i, priv_pend};
  assign cand = pend & en_q & ~act_q;

  lic_pick #(.N(N_TOT), .ID_W(ID_W)) u_pick (
    .cand_i (cand),
    .valid_o(pick_valid),
    .idx_o  (pick_idx)
  );

  always_comb begin
    for (int s = 0; s < N_SHR; s++)
      clr_d[s] = eoi_wr && (int'(wid) == N_PRIV + s);
  end

  always_comb begin
    rdata_d = '0;
    if (bus_addr == ADDR_W'(OFS_CTRL))
      rdata_d[0] = ctrl_en_q;
    if (bus_addr == ADDR_W'(OFS_READY))
      rdata_d = claim_ok ? DATA_W'(pick_idx) : DATA_W'(NO_IRQ);
    for (int w = 0; w < CFG_WORDS; w++)
      if (bus_addr == ADDR_W'(int'(OFS_CFG_BASE) + 4 * w))
        rdata_d = cfg_q[w*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_en_q <= 1'b0;
      cfg_q     <= '0;
      en_q      <= '0;
      act_q     <= '0;
      irq_q     <= 1'b0;
      clr_q     <= '0;
      rdata_q   <= '0;
    end else begin
      irq_q <= ctrl_en_q & (|cand);
      clr_q <= clr_d;
      if (rd_go)
        rdata_q <= rdata_d;
      if (wr_go && bus_addr == ADDR_W'(OFS_CTRL))
        ctrl_en_q <= bus_wdata[0];
      for (int w = 0; w < CFG_WORDS; w++)
        if (wr_go && bus_addr == ADDR_W'(int'(OFS_CFG_BASE) + 4 * w))
          cfg_q[w*DATA_W +: DATA_W] <= bus_wdata;
      for (int i = 0; i < N_TOT; i++) begin
        if (en_set_wr && int'(wid) == i) en_q[i] <= 1'b1;
        if (en_clr_wr && int'(wid) == i) en_q[i] <= 1'b0;
        if (eoi_wr && int'(wid) == i)    act_q[i] <= 1'b0;
        if (claim_vec[i])                act_q[i] <= 1'b1;
      end
    end
  end

  assign bus_rdata    = rdata_q;
  assign core_irq_o   = irq_q;
  assign shared_clr_o = clr_q;

  // R2: local enable off keeps the core line quiet
  assert_gate_off_R2: assert property (@(posedge clk) disable iff (rst)
    !ctrl_en_q |=> !core_irq_o);
  // R7: the picked ID is a real candidate, and none is missed
  assert_pick_cand_R7: assert property (@(posedge clk) disable iff (rst)
    pick_valid |-> ((cand >> pick_idx) & N_TOT'(1)) != '0);
  assert_pick_none_R7: assert property (@(posedge clk) disable iff (rst)
    !pick_valid |-> cand == '0);
  // R7: a claim marks its ID active
  assert_claim_active_R7: assert property (@(posedge clk) disable iff (rst)
    claim_ok |=> (act_q & $past(claim_vec)) != '0);
  // R9: clear pulses name at most one ID and follow a completion write
  assert_clr_onehot_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(shared_clr_o));
  assert_clr_cause_R9: assert property (@(posedge clk) disable iff (rst)
    (|shared_clr_o) |-> $past(eoi_wr));
endmodule

// File: tb/lic_local_cpu_test.sv
module lic_local_cpu_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] priv = '0;
  logic [31:0] shr = '0;
  logic        core_irq;
  logic [31:0] shr_clr;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  lic_local_cpu uut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .priv_irq_i(priv), .shared_req_i(shr), .core_irq_o(core_irq),
    .shared_clr_o(shr_clr)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk);
    bus_sel = 0;
    d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 irq", {31'b0, core_irq}, 0);
    chk("R1 clr", shr_clr, 0);
    rd(8'h00, d); chk("R1 ctrl", d, 0);
    rd(8'h40, d); chk("R1 cfg0", d, 0);
    rd(8'h10, d); chk("R1 ready", d, 32'h3FF);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(8'h00, 1); rd(8'h00, d); chk("R2 ctrl readback", d, 1);
    wr(8'h40, 32'hA5C3_0F1E); rd(8'h40, d); chk("R3 cfg0 readback", d, 32'hA5C3_0F1E);
    wr(8'h44, 32'h1234_8765); rd(8'h44, d); chk("R3 cfg1 readback", d, 32'h1234_8765);
    wr(8'h40, 0); wr(8'h44, 0);
  endtask

  task automatic t_level();
    logic [31:0] d;
    wr(8'h40, 32'h100);             // ID 4 level low
    wr(8'h14, 4); wr(8'h14, 6);
    cyc(3);
    chk("R8 irq level low", {31'b0, core_irq}, 1);
    rd(8'h10, d); chk("R4 level low pending", d, 4);
    cyc(3);
    chk("R8 irq drops when active", {31'b0, core_irq}, 0);
    priv[4] = 1; wr(8'h1C, 4); cyc(2);
    rd(8'h10, d); chk("R4 level low released", d, 32'h3FF);
    priv[6] = 1; cyc(2);
    rd(8'h10, d); chk("R4 level high pending", d, 6);
    priv[6] = 0; wr(8'h1C, 6); cyc(2);
    rd(8'h10, d); chk("R4 level high released", d, 32'h3FF);
    wr(8'h40, 0); priv[4] = 0;
    wr(8'h18, 4); wr(8'h18, 6);
  endtask

  task automatic t_edge();
    logic [31:0] d;
    wr(8'h44, 32'h300);             // ID 20 falling
    wr(8'h14, 20);
    priv[20] = 1; cyc(2);
    rd(8'h10, d); chk("R5 no fall yet", d, 32'h3FF);
    priv[20] = 0; cyc(3);
    chk("R8 irq on edge", {31'b0, core_irq}, 1);
    rd(8'h10, d); chk("R5 fall latched", d, 20);
    wr(8'h1C, 20); cyc(2);
    rd(8'h10, d); chk("R5 claim clears latch", d, 32'h3FF);
    wr(8'h18, 20); wr(8'h44, 0);
  endtask

  task automatic t_shared();
    logic [31:0] d;
    shr[5] = 1; priv[2] = 1;
    wr(8'h14, 37); wr(8'h14, 2); cyc(2);
    rd(8'h10, d); chk("R7 lowest first", d, 2);
    rd(8'h10, d); chk("R7 then shared", d, 37);
    rd(8'h10, d); chk("R7 none left", d, 32'h3FF);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = 8'h1C; bus_wdata = 37;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
    chk("R9 clr pulse", shr_clr, 32'h20);
    @(negedge clk);
    chk("R9 pulse one cycle", shr_clr, 0);
    shr[5] = 0;
    wr(8'h1C, 2);
    chk("R9 no pulse for private", shr_clr, 0);
    rd(8'h10, d); chk("R9 completed reclaimable", d, 2);
    priv[2] = 0; wr(8'h1C, 2);
    wr(8'h18, 37); wr(8'h18, 2);
  endtask

  task automatic t_enable();
    logic [31:0] d;
    priv[0] = 1; shr[0] = 1; cyc(2);
    wr(8'h14, 64); wr(8'h14, 32'h400);
    rd(8'h10, d); chk("R6 out-of-range ignored", d, 32'h3FF);
    wr(8'h14, 32); wr(8'h18, 32); cyc(2);
    rd(8'h10, d); chk("R6 disable", d, 32'h3FF);
    wr(8'h14, 32);
    wr(8'h00, 0); cyc(3);
    chk("R2 irq gated", {31'b0, core_irq}, 0);
    rd(8'h10, d); chk("R2 ready gated", d, 32'h3FF);
    wr(8'h00, 1); cyc(3);
    chk("R8 irq back", {31'b0, core_irq}, 1);
    rd(8'h10, d); chk("R6 enabled after gate", d, 32);
    wr(8'h18, 32); wr(8'h1C, 32);
    cyc(3);
    chk("R8 irq idle", {31'b0, core_irq}, 0);
    priv[0] = 0; shr[0] = 0;
  endtask

  task automatic t_same_cycle(bit second_edge, logic [31:0] exp);
    logic [31:0] d;
    wr(8'h40, 32'h80);              // ID 3 rising
    wr(8'h14, 3);
    priv[3] = 1; cyc(2);
    priv[3] = 0; cyc(2);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = 8'h10;
    if (second_edge) priv[3] = 1;
    @(negedge clk);
    bus_sel = 0;
    chk("R10 first claim", bus_rdata, 3);
    wr(8'h1C, 3); cyc(1);
    rd(8'h10, d); chk("R10 edge during claim", d, exp);
    wr(8'h1C, 3);
    priv[3] = 0; wr(8'h18, 3); wr(8'h40, 0);
  endtask

  initial begin
    cyc(4);
    rst = 0;
    cyc(1);
    t_reset();
    t_regs();
    t_level();
    t_edge();
    t_shared();
    t_enable();
    t_same_cycle(1'b0, 32'h3FF);
    t_same_cycle(1'b1, 32'd3);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule